// File: doc/BRIEF.md
# Two-Stage I2C Bit-Clock Prescaler

This block turns the core clock into the timing base of an I2C bit engine. Software writes one configuration byte that holds a 4-bit multiplier and a 3-bit exponent. The block feeds the core clock through a chain of counters: a fixed stage of THP+1, a stage of M+1, a power-of-two stage of 2^N, and a final stage of 10. It toggles the SCL phase on every wrap of the last stage. The full SCL period is therefore core cycles × 20 × (M+1) × (THP+1) × 2^N.

The block gives the bit engine three outputs. A one-cycle tick marks each SCL half-period edge. A one-cycle mid-point pulse falls halfway through each half-period and serves as the SDA sampling point. The third output is the SCL phase level itself. A new setting, or a low enable, clears every counter, so timing restarts cleanly from a full period.

Top module: `bitclk_prescaler`

## Requirements
- R1: After reset, edge_tick, mid_tick and scl_phase are all low.
- R2: The multiplier M is taken from cfg_byte[6:3] and the exponent N from cfg_byte[2:0]. Bit 7 of cfg_byte has no effect on timing.
- R3: In steady operation, consecutive edge_tick pulses are exactly H = 10 × (M+1) × (THP+1) × 2^N core cycles apart. Each pulse lasts one cycle.
- R4: scl_phase changes level on exactly the cycles where edge_tick is high, so its full period is 2H.
- R5: Exactly H/2 cycles after each edge_tick, mid_tick pulses for one cycle. It is never high in the same cycle as edge_tick.
- R6: A cfg_we write clears all counters and forces scl_phase low. The first edge_tick comes exactly H cycles after the write edge, using the new setting.
- R7: While enable is low, the counters are held at zero and a cfg_we write still updates the setting. Once enable is high, the first edge_tick comes on the H-th rising edge, counting the first edge at which enable is sampled high.
- R8: While enable is low, edge_tick and mid_tick stay low and scl_phase is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low holds all counters at zero |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_byte | input | 8 | Setting: [6:3] multiplier M, [2:0] exponent N, [7] unused |
| edge_tick | output | 1 | One-cycle pulse on every SCL half-period boundary |
| mid_tick | output | 1 | One-cycle pulse halfway through each half-period |
| scl_phase | output | 1 | Derived SCL level, toggled by edge_tick |

## Verification
Any counter that has slipped or holds a stale limit shows up at the ports as an edge_tick interval that is off from H. A first tick measured from a write or from enable rising exposes a missed clear in the very next period. A mid_tick offset from H/2 points to a fault in the last stage or the mid-point decode within one half-period. A wrong field slice shows as a period off by a factor of two or more, which the bench can see on the first tick after the write.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int FINAL_DIV = 10;
  localparam int MID_CNT   = FINAL_DIV / 2 - 1;
  localparam int NSTG      = 4;

  // counter width wide enough for the fixed stage and the 2^N stage (max 127)
  function automatic int stage_width(input int thp);
    int w;
    w = $clog2(thp + 1);
    return (w > 7) ? w : 7;
  endfunction

  // core cycles between two edge ticks
  function automatic int unsigned half_cycles(input int m, input int n, input int thp);
    return FINAL_DIV * (m + 1) * (thp + 1) * (1 << n);
  endfunction
endpackage

// File: rtl/presc_cfg.sv
module presc_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_byte,
  output logic [3:0] m_val,
  output logic [2:0] n_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val <= '0;
      n_val <= '0;
    end else if (cfg_we) begin
      m_val <= cfg_byte[6:3];
      n_val <= cfg_byte[2:0];
    end
  end

  // R2
  field_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (m_val == $past(cfg_byte[6:3]) && n_val == $past(cfg_byte[2:0])));
endmodule

// File: rtl/presc_stage.sv
module presc_stage #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/bitclk_prescaler.sv
module bitclk_prescaler #(
  parameter int THP = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cfg_we,
  input  logic [7:0] cfg_byte,
  output logic       edge_tick,
  output logic       mid_tick,
  output logic       scl_phase
);
  import presc_pkg::*;

  localparam int SW = stage_width(THP);

  logic [3:0]      m_val;
  logic [2:0]      n_val;
  logic            clr;
  logic [NSTG-1:0] step;
  logic [NSTG-1:0] wrap;
  logic [SW-1:0]   lim [NSTG];
  logic [SW-1:0]   cnt [NSTG];
  logic            mid_hit;

  presc_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
    .m_val(m_val), .n_val(n_val)
  );

  assign clr = cfg_we || !enable;

  always_comb begin
    lim[0] = SW'(THP);
    lim[1] = SW'(m_val);
    lim[2] = SW'((1 << n_val) - 1);
    lim[3] = SW'(FINAL_DIV - 1);
  end

  assign step = {wrap[NSTG-2:0], enable};

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    presc_stage #(.W(SW)) i_stage (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step[g]),
      .lim(lim[g]), .cnt(cnt[g]), .wrap(wrap[g])
    );
  end

  assign mid_hit = step[NSTG-1] && (cnt[NSTG-1] == SW'(MID_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_tick <= 1'b0;
      mid_tick  <= 1'b0;
      scl_phase <= 1'b0;
    end else begin
      edge_tick <= wrap[NSTG-1] && !clr;
      mid_tick  <= mid_hit && !clr;
      if (clr)                scl_phase <= 1'b0;
      else if (wrap[NSTG-1])  scl_phase <= ~scl_phase;
    end
  end

  // R4
  scl_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> scl_phase != $past(scl_phase));

  // R4
  scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_tick && !$past(clr)) |-> $stable(scl_phase));

  // R5
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edge_tick, mid_tick}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!edge_tick && !mid_tick && !scl_phase));
endmodule

// File: tb/test_bitclk_prescaler.sv
module test_bitclk_prescaler;
  localparam int THP = 2;
  localparam int NV  = 5;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'h99, 8'h78, 8'h07, 8'h2A};
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic edge_tick, mid_tick, scl_phase;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bitclk_prescaler #(.THP(THP)) i_bitclk_prescaler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_byte(cfg_byte), .edge_tick(edge_tick), .mid_tick(mid_tick),
    .scl_phase(scl_phase)
  );

  function automatic int expect_half(input logic [7:0] b);
    int m, n;
    m = b[6:3];
    n = b[2:0];
    return ((THP + 1) * (m + 1) * 20 / 2) << n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts rising edges until the chosen output is seen high at a falling edge
  task automatic count_until(input bit want_mid, output int n);
    n = 0;
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (want_mid ? mid_tick : edge_tick) return;
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_byte = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, h, busy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 edge_tick", edge_tick, 0);
    check("R1 mid_tick", mid_tick, 0);
    check("R1 scl_phase", scl_phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    for (int v = 0; v < NV; v++) begin
      h = expect_half(VEC[v]);
      write_cfg(VEC[v]);
      // R6 scl cleared by the write
      check("R6 scl low after write", scl_phase, 0);
      count_until(1'b0, n);
      // R6 first tick H edges after the write edge (one edge already consumed); R2 field slice
      check("R6/R2 first tick latency", n + 1, h + 1);
      check("R4 scl high after first tick", scl_phase, 1);
      count_until(1'b0, n);
      check("R3 half period", n, h);
      check("R4 scl low after second tick", scl_phase, 0);
      count_until(1'b1, n);
      check("R5 mid offset", n, h / 2);
      count_until(1'b0, n);
      check("R3 tick after mid", n, h / 2);
    end

    // R7/R8: enable low, write while idle, stay quiet
    @(negedge clk);
    enable = 1'b0;
    write_cfg(8'h08);
    busy = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (edge_tick || mid_tick || scl_phase) busy++;
    end
    check("R8 quiet while disabled", busy, 0);
    enable = 1'b1;
    count_until(1'b0, n);
    check("R7 latency after enable", n, expect_half(8'h08));

    // R6 mid-period rewrite restarts the count
    write_cfg(8'h00);
    count_until(1'b0, n);
    repeat (7) @(negedge clk);
    write_cfg(8'h00);
    count_until(1'b0, n);
    check("R6 restart on same value", n, expect_half(8'h00));
    // R2 bit 7 ignored: 8'h80 equals M0 N0
    write_cfg(8'h80);
    count_until(1'b0, n);
    check("R2 bit7 ignored", n, expect_half(8'h00));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule